// File: doc/BRIEF.md
# Programmable interval timer channel

This block is a single 16-bit down-counting timer channel that a host programs and reads through byte-wide ports. The host first sends a control byte that picks the operating mode. It then writes the start count as two bytes, low byte first. Writing the high byte starts the channel. The counter steps down once for each single-cycle `tick_en` pulse. That pulse stands for a fixed-rate timer clock of roughly 1.19 MHz, which an enclosing design derives from the system clock.

Three modes are supported:
- **Terminal-count mode** fires once. When the count runs out, the output level goes high and stays high.
- **Rate-generator mode** and **square-wave mode** fire repeatedly, every count-minus-one ticks, and restart themselves after each expiry.

Every expiry also gives a one-cycle pulse. The host can freeze a snapshot of the live count into a hold register and read it out two bytes at a time. A control byte that asks for a feature the channel lacks raises a sticky error flag and changes nothing else.

Top module: `pit_channel`

## Requirements
- R1: After reset the output level, the expiry pulse and the error flag are low, and reading two bytes returns a count of zero.
- R2: A control byte carries the access field in bits [5:4], the mode field in bits [3:1] and the BCD bit in bit 0; bits [7:6] are ignored. The channel accepts only these values:
  - access 2'b00 is a latch command;
  - access 2'b11 selects low-then-high byte access;
  - mode 3'b000 is terminal count, 3'b010 is rate generator and 3'b011 is square wave.
  Any other non-latch byte, or one with BCD set, sets a sticky error flag and leaves the mode unchanged.
- R3: A write while the write pointer is on the low byte stores that byte, disarms the channel, cancels any pending expiry, drives the output level low and moves the pointer to the high byte.
- R4: A write on the high byte forms the count {high, low}, arms the channel and returns the pointer to the low byte. The period is the count in terminal-count mode and count minus one in the two periodic modes. The first expiry comes on the period-th tick after arming.
- R5: When the period would be zero, the high-byte write leaves the channel disarmed and the live count at zero. This happens for a count of 0 in any mode, or a count of 0 or 1 in a periodic mode.
- R6: The live count changes only on cycles with `tick_en` high while armed. The tick that finds the count at 1 is the expiry. `expire_pulse` is high for exactly the cycle after that tick.
- R7: In terminal-count mode an expiry sets the output level high, disarms the channel and leaves a live count of 0. The level stays high until the next low-byte write.
- R8: In the periodic modes an expiry reloads the period, so expiries repeat every period ticks and the output level is not raised.
- R9: A latch command copies the live count into the hold register and points the read pointer at the low byte, but only when no latch is already held. Otherwise it is ignored.
- R10: `rd_data` shows the low byte, then after one `rd_en` the high byte, alternating. While a latch is held it shows the held value, and reading the held high byte releases the latch. Otherwise it shows the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timer clock pulse |
| ctl_we | input | 1 | Control byte strobe |
| ctl_data | input | 8 | Control byte |
| wr_en | input | 1 | Count byte write strobe |
| wr_data | input | 8 | Count byte |
| rd_en | input | 1 | Read pointer advance strobe |
| rd_data | output | 8 | Byte currently selected for reading |
| out_level | output | 1 | Terminal-count output level |
| expire_pulse | output | 1 | One-cycle expiry pulse |
| cfg_error | output | 1 | Sticky rejected-control flag |

## Verification
The bench targets these corner cases, and what a faulty design would do in each:
- **A second latch command while one is held.** A design that re-latches would return a newer count than the one first frozen.
- **Reading the held high byte.** A design that never releases would keep returning the stale snapshot after the pair is read.
- **Count 1 in a periodic mode.** A design without the zero-period guard would fire at once or wrap to 65535.
- **A low-byte write in the middle of a period.** A design that kept counting would still expire.
- **A BCD or odd-access control byte.** A design that applies it anyway would switch to terminal-count mode, which shows up as a longer period and a raised output level.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [2:0] {
      MODE_TERM   = 3'd0,
      MODE_RATE   = 3'd2,
      MODE_SQUARE = 3'd3
   } pit_mode_e;

   localparam logic [1:0] ACC_LATCH = 2'b00;
   localparam logic [1:0] ACC_LOHI  = 2'b11;

   function automatic logic mode_legal(input logic [2:0] m);
      return (m == 3'd0) || (m == 3'd2) || (m == 3'd3);
   endfunction

endpackage

// File: rtl/pit_ctl_decode.sv
module pit_ctl_decode
   import pit_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_we,
   input  logic [7:0]      ctl_data,
   output logic            latch_cmd,
   output pit_mode_e       mode_q,
   output logic            cfg_error
);

   logic [1:0] acc_f;
   logic [2:0] mode_f;
   logic       bcd_f;
   logic       prog_ok;
   logic       prog_bad;

   always_comb begin
      acc_f     = ctl_data[5:4];
      mode_f    = ctl_data[3:1];
      bcd_f     = ctl_data[0];
      latch_cmd = ctl_we && (acc_f == ACC_LATCH);
      prog_ok   = ctl_we && (acc_f == ACC_LOHI) && mode_legal(mode_f) && !bcd_f;
      prog_bad  = ctl_we && (acc_f != ACC_LATCH) && !prog_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= MODE_TERM;
         cfg_error <= 1'b0;
      end else begin
         if (prog_ok)
            mode_q <= pit_mode_e'(mode_f);
         if (prog_bad)
            cfg_error <= 1'b1;
      end
   end

endmodule

// File: rtl/pit_byte_port.sv
module pit_byte_port #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              latch_cmd,
   input  logic [CNT_W-1:0]  live_cnt,
   output logic              lo_stb,
   output logic              load_stb,
   output logic [CNT_W-1:0]  load_val,
   output logic              wr_hi_sel,
   output logic [BYTE_W-1:0] rd_data
);

   localparam int NB = CNT_W / BYTE_W;

   logic              wptr;
   logic [BYTE_W-1:0] lo_stage;
   logic              rptr;
   logic              held;
   logic [CNT_W-1:0]  hold_val;
   logic [CNT_W-1:0]  rd_src;
   logic [BYTE_W-1:0] lane [NB];

   assign wr_hi_sel = wptr;
   assign lo_stb    = wr_en && !wptr;
   assign load_stb  = wr_en && wptr;
   assign load_val  = {wr_data, lo_stage};
   assign rd_src    = held ? hold_val : live_cnt;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign lane[i] = rd_src[i*BYTE_W +: BYTE_W];
   end

   assign rd_data = lane[rptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr     <= 1'b0;
         lo_stage <= '0;
      end else if (wr_en) begin
         wptr <= ~wptr;
         if (!wptr)
            lo_stage <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rptr     <= 1'b0;
         held     <= 1'b0;
         hold_val <= '0;
      end else if (latch_cmd) begin
         if (!held) begin
            held     <= 1'b1;
            hold_val <= live_cnt;
            rptr     <= 1'b0;
         end
      end else if (rd_en) begin
         rptr <= ~rptr;
         if (rptr && held)
            held <= 1'b0;
      end
   end

endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             lo_stb,
   input  logic             load_stb,
   input  logic [CNT_W-1:0] load_val,
   input  pit_mode_e        mode,
   output logic [CNT_W-1:0] cnt,
   output logic             out_level,
   output logic             expire_pulse
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] period;
   logic             armed;
   logic             periodic;
   logic [CNT_W-1:0] per_next;
   logic             arm_ok;

   always_comb begin
      periodic = (mode != MODE_TERM);
      per_next = periodic ? (load_val - ONE) : load_val;
      arm_ok   = periodic ? (load_val > ONE) : (load_val != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt          <= '0;
         period       <= '0;
         armed        <= 1'b0;
         out_level    <= 1'b0;
         expire_pulse <= 1'b0;
      end else begin
         expire_pulse <= 1'b0;
         if (lo_stb) begin
            armed     <= 1'b0;
            out_level <= 1'b0;
         end else if (load_stb) begin
            period <= arm_ok ? per_next : '0;
            cnt    <= arm_ok ? per_next : '0;
            armed  <= arm_ok;
         end else if (tick_en && armed) begin
            if (cnt == ONE) begin
               expire_pulse <= 1'b1;
               if (periodic) begin
                  cnt <= period;
               end else begin
                  cnt       <= '0;
                  armed     <= 1'b0;
                  out_level <= 1'b1;
               end
            end else begin
               cnt <= cnt - ONE;
            end
         end
      end
   end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              ctl_we,
   input  logic [7:0]        ctl_data,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data,
   output logic              out_level,
   output logic              expire_pulse,
   output logic              cfg_error
);

   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("pit_channel: CNT_W must be exactly two bytes wide");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("pit_channel: BYTE_W too small");
   end

   logic             latch_cmd;
   pit_mode_e        mode_q;
   logic             lo_stb;
   logic             load_stb;
   logic [CNT_W-1:0] load_val;
   logic             wr_hi_sel;
   logic [CNT_W-1:0] live_cnt;

   pit_ctl_decode u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_data  (ctl_data),
      .latch_cmd (latch_cmd),
      .mode_q    (mode_q),
      .cfg_error (cfg_error)
   );

   pit_byte_port #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_en     (rd_en),
      .latch_cmd (latch_cmd),
      .live_cnt  (live_cnt),
      .lo_stb    (lo_stb),
      .load_stb  (load_stb),
      .load_val  (load_val),
      .wr_hi_sel (wr_hi_sel),
      .rd_data   (rd_data)
   );

   pit_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_en      (tick_en),
      .lo_stb       (lo_stb),
      .load_stb     (load_stb),
      .load_val     (load_val),
      .mode         (mode_q),
      .cnt          (live_cnt),
      .out_level    (out_level),
      .expire_pulse (expire_pulse)
   );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_en,
   input logic wr_en,
   input logic wr_hi_sel,
   input logic out_level,
   input logic expire_pulse,
   input logic cfg_error
);

   a_r6_expire_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      expire_pulse |-> $past(tick_en));

   a_r2_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |=> cfg_error);

   a_r3_low_write_quiets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hi_sel) |=> (!out_level && !expire_pulse));

   a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (out_level && !(wr_en && !wr_hi_sel)) |=> out_level);

   a_r7_rise_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_level) |-> expire_pulse);

endmodule

bind pit_channel pit_channel_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_en      (tick_en),
   .wr_en        (wr_en),
   .wr_hi_sel    (wr_hi_sel),
   .out_level    (out_level),
   .expire_pulse (expire_pulse),
   .cfg_error    (cfg_error)
);

// File: tb/pit_channel_tb_top.sv
module pit_channel_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_data = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       out_level;
   logic       expire_pulse;
   logic       cfg_error;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model state
   int   m_cnt = 0, m_per = 0, m_mode = 0, m_hold = 0;
   bit   m_arm = 0, m_out = 0, m_err = 0, m_wptr = 0, m_rptr = 0, m_held = 0;
   int   m_lo = 0;

   always #4 clk = ~clk;

   pit_channel dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_en      (tick_en),
      .ctl_we       (ctl_we),
      .ctl_data     (ctl_data),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_en        (rd_en),
      .rd_data      (rd_data),
      .out_level    (out_level),
      .expire_pulse (expire_pulse),
      .cfg_error    (cfg_error)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_byte();
      int src;
      src = m_held ? m_hold : m_cnt;
      return m_rptr ? ((src >> 8) & 255) : (src & 255);
   endfunction

   task automatic do_ctl(input logic [7:0] b);
      int acc, md;
      @(negedge clk);
      ctl_we = 1'b1; ctl_data = b;
      @(negedge clk);
      ctl_we = 1'b0;
      acc = int'(b[5:4]); md = int'(b[3:1]);
      if (acc == 0) begin
         if (!m_held) begin m_held = 1; m_hold = m_cnt; m_rptr = 0; end
      end else if (acc == 3 && (md == 0 || md == 2 || md == 3) && !b[0]) begin
         m_mode = md;
      end else begin
         m_err = 1;
      end
      chk("R2 error flag", {31'd0, cfg_error}, {31'd0, m_err});
   endtask

   task automatic do_wr(input logic [7:0] b);
      int val;
      bit per_mode, ok;
      @(negedge clk);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
      if (!m_wptr) begin
         m_lo = int'(b); m_arm = 0; m_out = 0; m_wptr = 1;
      end else begin
         val = int'(b) * 256 + m_lo;
         per_mode = (m_mode != 0);
         ok = per_mode ? (val > 1) : (val != 0);
         m_per = ok ? (per_mode ? val - 1 : val) : 0;
         m_cnt = m_per; m_arm = ok; m_wptr = 0;
      end
      chk("R3 level after write", {31'd0, out_level}, {31'd0, m_out});
      chk("R4 no pulse on write", {31'd0, expire_pulse}, 32'd0);
   endtask

   task automatic do_tick();
      bit e;
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      e = 0;
      if (m_arm) begin
         if (m_cnt == 1) begin
            e = 1;
            if (m_mode != 0) m_cnt = m_per;
            else begin m_cnt = 0; m_arm = 0; m_out = 1; end
         end else m_cnt = m_cnt - 1;
      end
      chk("R6 expire pulse", {31'd0, expire_pulse}, {31'd0, e});
      chk("R7 output level", {31'd0, out_level}, {31'd0, m_out});
   endtask

   task automatic do_rd();
      @(negedge clk);
      chk("R10 read byte", {24'd0, rd_data}, exp_byte());
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (m_rptr && m_held) m_held = 0;
      m_rptr = !m_rptr;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) do_tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int r;
      void'($urandom(32'd7331));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 out low", {31'd0, out_level}, 32'd0);
      chk("R1 pulse low", {31'd0, expire_pulse}, 32'd0);
      chk("R1 error low", {31'd0, cfg_error}, 32'd0);
      do_rd(); do_rd();

      // R7 terminal count, count 3
      do_ctl(8'h30); do_wr(8'd3); do_wr(8'd0);
      ticks(2);
      chk("R4 no early expiry", {31'd0, out_level}, 32'd0);
      do_tick();
      chk("R7 level high at count end", {31'd0, out_level}, 32'd1);
      ticks(3);
      chk("R7 level stays high", {31'd0, out_level}, 32'd1);
      do_rd(); do_rd();
      // R3 low-byte write drops level
      do_wr(8'd5);
      chk("R3 level low after low write", {31'd0, out_level}, 32'd0);
      do_wr(8'd0);

      // R9 sticky latch, R10 release
      ticks(2);
      do_ctl(8'h00);
      do_tick();
      do_ctl(8'h00);
      do_rd();
      do_rd();
      do_rd(); do_rd();

      // R8 rate generator, count 4 -> period 3
      do_ctl(8'h34); do_wr(8'd4); do_wr(8'd0);
      ticks(7);
      chk("R8 level stays low periodic", {31'd0, out_level}, 32'd0);

      // R5 count 1 in square-wave gives no arming
      do_ctl(8'h36); do_wr(8'd1); do_wr(8'd0);
      ticks(4);
      do_rd(); do_rd();
      // count 2: period 1, every tick expires
      do_wr(8'd2); do_wr(8'd0);
      ticks(3);

      // R3 mid-period cancel
      do_wr(8'd3); do_wr(8'd0);
      do_tick();
      do_wr(8'd9);
      ticks(3);
      do_wr(8'd0);

      // R2 rejected control bytes keep the mode periodic
      do_ctl(8'h31);
      do_ctl(8'h10);
      do_wr(8'd3); do_wr(8'd0);
      ticks(3);
      chk("R2 mode unchanged after reject", {31'd0, out_level}, 32'd0);

      // constrained random mix
      for (int k = 0; k < 4000; k++) begin
         r = int'($urandom % 100);
         if (r < 55) do_tick();
         else if (r < 70) do_rd();
         else if (r < 80) begin
            case ($urandom % 5)
               0: do_ctl(8'h30);
               1: do_ctl(8'h34);
               2: do_ctl(8'h36);
               3: do_ctl(8'h00);
               default: do_ctl(($urandom % 20 == 0) ? 8'($urandom) : 8'h00);
            endcase
         end else begin
            if (m_wptr) do_wr(($urandom % 8 == 0) ? 8'd1 : 8'd0);
            else        do_wr(8'($urandom % 7));
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule